// File: doc/BRIEF.md
# Virtual CPU Interface Control Register Block

This block holds the per-virtual-CPU interrupt interface settings that a hypervisor saves and restores when it switches virtual machines. The settings are a priority mask, two binary-point values (one per interrupt group), an end-of-interrupt mode bit, a common-binary-point bit, a fast-interrupt enable, an acknowledge-control bit and one enable per interrupt group. One set of storage bits can be reached through two kinds of view. A packed 32-bit view carries every field at once. Separate narrow views each carry one setting or one small group of bits.

Each request carries a view selector, a read/write flag, the privilege level of the requester, a trap-enable input and a system-register-enable input for each of levels 2 and 3. The block checks every access against the privilege rules. It then either performs the access or reports it as undefined or trapped, together with a syndrome code. A configuration input marks an implementation where the system register interface is always on. In that case two control bits read as constants.

The response is registered. It appears one clock after the request, and a write changes storage on that same edge.

Top module: `vcpu_ifc_ctl`

## Requirements
- R1: A successful read of the packed view (view code 0) returns the priority mask at bits 31:24, the group-0 binary point at 23:21, the group-1 binary point at 20:18, the end-of-interrupt mode at bit 9, the common-binary-point bit at bit 4, the fast-interrupt enable at bit 3, the acknowledge-control bit at bit 2, the group-1 enable at bit 1 and the group-0 enable at bit 0. A packed write loads every field from those same positions.
- R2: Bits 8:5 and 17:10 of the packed view always read as zero, and writing ones to them changes no stored field.
- R3: The narrow views share storage with the packed view, and all of them are right-justified with zero upper bits. View code 1 is the priority mask in bits 7:0, code 2 the group-0 binary point in bits 2:0, code 3 the group-1 binary point in bits 2:0, code 4 the control bits (bit 0 end-of-interrupt mode, bit 1 common binary point, bit 2 fast-interrupt enable, bit 3 acknowledge control) and code 5 the group enables (bit 0 group 0, bit 1 group 1). A write through any view is visible through every other view.
- R4: While the common-binary-point bit is 1, a read of view code 3 returns the group-0 binary point plus one, saturated at 7.
- R5: While the common-binary-point bit is 1, a write through view code 3 leaves the stored group-1 binary point unchanged, as seen in the packed view.
- R6: Any access at privilege level 0 is reported undefined.
- R7: At privilege level 1, an access with trap-enable set is reported as a trap with syndrome 0x03. Without trap-enable it is reported undefined. Trap and undefined are never both reported.
- R8: At privilege level 2 the access goes through only when the level-2 system-register enable is 1, and at level 3 only when the level-3 enable is 1. Otherwise it is reported undefined.
- R9: When the always-on configuration input is 1, the fast-interrupt enable reads as 1 and the acknowledge-control bit reads as 0, in both the packed and the control view, whatever is stored.
- R10: Reset (synchronous, active high) clears every stored field to zero and clears all response outputs.
- R11: Every request gets a response strobe exactly one cycle later, and no response appears without a request. Writes, and faulting accesses, return zero data. A faulting write changes no stored state.
- R12: View codes 6 and 7 are reported undefined at levels 2 and 3, even when the access would otherwise be allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | View selector (0 packed, 1 to 5 narrow views) |
| req_priv | input | PRIV_W | Privilege level of the requester (0 to 3) |
| req_wdata | input | 32 | Write data for the selected view |
| trap_en | input | 1 | Level-1 accesses trap to level 2 instead of being undefined |
| sre_l2 | input | 1 | System-register enable for level 2 |
| sre_l3 | input | 1 | System-register enable for level 3 |
| sre_fixed | input | 1 | Configuration: system register interface always on |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data (zero for writes and faults) |
| rsp_undef | output | 1 | Access reported undefined |
| rsp_trap | output | 1 | Access reported as a trap to level 2 |
| rsp_syndrome | output | SYND_W | Trap syndrome code, zero when no trap |

## Verification
Every result of this block is due on the first rising edge after the request is presented. That covers the response strobe, the data, the undefined and trap flags and the syndrome. The stored fields change on that same edge, so the next request already sees a write. The bench drives each request on a falling edge and compares all response outputs on the following falling edge. It computes the expected response from a behavioural model taken before that request's write. It applies the model update only when the access is allowed, so any stored-state change shows up in the next read's comparison. Idle cycles and the cycles after reset are compared in the same way, with the strobes expected low.

// File: rtl/vcpu_ifc_pkg.sv
package vcpu_ifc_pkg;

  localparam int WORD_W = 32;
  localparam int PRIO_W = 8;
  localparam int BP_W   = 3;
  localparam int VIEW_W = 3;

  // packed-word field positions (decoded by software on the other side)
  localparam int POS_PMASK = 24;
  localparam int POS_BP0   = 21;
  localparam int POS_BP1   = 18;
  localparam int POS_EOIM  = 9;
  localparam int POS_CBPR  = 4;
  localparam int POS_FIQ   = 3;
  localparam int POS_ACK   = 2;
  localparam int POS_EN1   = 1;
  localparam int POS_EN0   = 0;

  localparam logic [WORD_W-1:0] RSVD_MASK = 32'h0003_FDE0;

  typedef enum logic [VIEW_W-1:0] {
    VIEW_PACKED = 3'd0,
    VIEW_PMASK  = 3'd1,
    VIEW_BP0    = 3'd2,
    VIEW_BP1    = 3'd3,
    VIEW_CTRL   = 3'd4,
    VIEW_EN     = 3'd5
  } view_e;

  typedef enum logic [1:0] {
    GATE_PASS  = 2'd0,
    GATE_UNDEF = 2'd1,
    GATE_TRAP  = 2'd2
  } gate_e;

  typedef struct packed {
    logic [PRIO_W-1:0] pmask;
    logic [BP_W-1:0]   bp0;
    logic [BP_W-1:0]   bp1;
    logic              eoim;
    logic              cbpr;
    logic              fiqen;
    logic              ackctl;
    logic              en1;
    logic              en0;
  } vctl_t;

  function automatic logic [BP_W-1:0] bp_plus_one_sat(input logic [BP_W-1:0] b);
    return (&b) ? b : b + BP_W'(1);
  endfunction

endpackage

// File: rtl/vcpu_access_gate.sv
module vcpu_access_gate
  import vcpu_ifc_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic [PRIV_W-1:0] priv,
  input  logic              trap_en,
  input  logic              sre_l2,
  input  logic              sre_l3,
  input  logic              view_known,
  output gate_e             verdict
);

  // privilege is judged first; the view selector matters only once allowed
  always_comb begin
    verdict = GATE_UNDEF;
    if (priv == PRIV_W'(1)) begin
      verdict = trap_en ? GATE_TRAP : GATE_UNDEF;
    end else if (priv == PRIV_W'(2)) begin
      verdict = (sre_l2 && view_known) ? GATE_PASS : GATE_UNDEF;
    end else if (priv == PRIV_W'(3)) begin
      verdict = (sre_l3 && view_known) ? GATE_PASS : GATE_UNDEF;
    end
  end

endmodule

// File: rtl/vcpu_ctl_store.sv
module vcpu_ctl_store
  import vcpu_ifc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [VIEW_W-1:0] view,
  input  logic [WORD_W-1:0] wdata,
  output vctl_t             st
);

  logic rsvd_unused;
  assign rsvd_unused = ^(wdata & RSVD_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (wr_en) begin
      case (view)
        VIEW_PACKED: begin
          st.pmask  <= wdata[POS_PMASK +: PRIO_W];
          st.bp0    <= wdata[POS_BP0 +: BP_W];
          st.bp1    <= wdata[POS_BP1 +: BP_W];
          st.eoim   <= wdata[POS_EOIM];
          st.cbpr   <= wdata[POS_CBPR];
          st.fiqen  <= wdata[POS_FIQ];
          st.ackctl <= wdata[POS_ACK];
          st.en1    <= wdata[POS_EN1];
          st.en0    <= wdata[POS_EN0];
        end
        VIEW_PMASK: st.pmask <= wdata[PRIO_W-1:0];
        VIEW_BP0:   st.bp0   <= wdata[BP_W-1:0];
        VIEW_BP1: begin
          // derived while the common binary point is on: write dropped
          if (!st.cbpr) st.bp1 <= wdata[BP_W-1:0];
        end
        VIEW_CTRL: begin
          st.eoim   <= wdata[0];
          st.cbpr   <= wdata[1];
          st.fiqen  <= wdata[2];
          st.ackctl <= wdata[3];
        end
        VIEW_EN: begin
          st.en0 <= wdata[0];
          st.en1 <= wdata[1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vcpu_ctl_view.sv
module vcpu_ctl_view
  import vcpu_ifc_pkg::*;
(
  input  vctl_t             st,
  input  logic [VIEW_W-1:0] view,
  input  logic              sre_fixed,
  output logic [WORD_W-1:0] rdata
);

  logic fiq_rd;
  logic ack_rd;

  assign fiq_rd = st.fiqen | sre_fixed;
  assign ack_rd = st.ackctl & ~sre_fixed;

  always_comb begin
    rdata = '0;
    case (view)
      VIEW_PACKED: begin
        rdata[POS_PMASK +: PRIO_W] = st.pmask;
        rdata[POS_BP0 +: BP_W]     = st.bp0;
        rdata[POS_BP1 +: BP_W]     = st.bp1;
        rdata[POS_EOIM]            = st.eoim;
        rdata[POS_CBPR]            = st.cbpr;
        rdata[POS_FIQ]             = fiq_rd;
        rdata[POS_ACK]             = ack_rd;
        rdata[POS_EN1]             = st.en1;
        rdata[POS_EN0]             = st.en0;
      end
      VIEW_PMASK: rdata[PRIO_W-1:0] = st.pmask;
      VIEW_BP0:   rdata[BP_W-1:0]   = st.bp0;
      VIEW_BP1:   rdata[BP_W-1:0]   = st.cbpr ? bp_plus_one_sat(st.bp0) : st.bp1;
      VIEW_CTRL:  rdata[3:0]        = {ack_rd, fiq_rd, st.cbpr, st.eoim};
      VIEW_EN:    rdata[1:0]        = {st.en1, st.en0};
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/vcpu_ifc_ctl.sv
module vcpu_ifc_ctl
  import vcpu_ifc_pkg::*;
#(
  parameter int                PRIV_W    = 2,
  parameter int                SYND_W    = 6,
  parameter logic [SYND_W-1:0] TRAP_SYND = 'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VIEW_W-1:0] req_view,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              trap_en,
  input  logic              sre_l2,
  input  logic              sre_l3,
  input  logic              sre_fixed,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_undef,
  output logic              rsp_trap,
  output logic [SYND_W-1:0] rsp_syndrome
);

  gate_e             verdict;
  logic              view_known;
  logic              wr_en;
  vctl_t             st;
  logic [WORD_W-1:0] rd_word;

  assign view_known = (req_view <= VIEW_W'(VIEW_EN));

  vcpu_access_gate #(.PRIV_W(PRIV_W)) u_gate (
    .priv       (req_priv),
    .trap_en    (trap_en),
    .sre_l2     (sre_l2),
    .sre_l3     (sre_l3),
    .view_known (view_known),
    .verdict    (verdict)
  );

  assign wr_en = req_valid && req_write && (verdict == GATE_PASS);

  vcpu_ctl_store u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .view  (req_view),
    .wdata (req_wdata),
    .st    (st)
  );

  vcpu_ctl_view u_view (
    .st        (st),
    .view      (req_view),
    .sre_fixed (sre_fixed),
    .rdata     (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_undef    <= 1'b0;
      rsp_trap     <= 1'b0;
      rsp_syndrome <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_undef    <= req_valid && (verdict == GATE_UNDEF);
      rsp_trap     <= req_valid && (verdict == GATE_TRAP);
      rsp_syndrome <= (req_valid && (verdict == GATE_TRAP)) ? TRAP_SYND : '0;
      rsp_rdata    <= (req_valid && !req_write && (verdict == GATE_PASS)) ? rd_word : '0;
    end
  end

endmodule

// File: rtl/vcpu_ifc_ctl_chk.sv
module vcpu_ifc_ctl_chk
  import vcpu_ifc_pkg::*;
#(
  parameter int                PRIV_W    = 2,
  parameter int                SYND_W    = 6,
  parameter logic [SYND_W-1:0] TRAP_SYND = 'h03
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [VIEW_W-1:0] req_view,
  input logic [PRIV_W-1:0] req_priv,
  input logic              trap_en,
  input logic              sre_l2,
  input logic              sre_fixed,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic              rsp_undef,
  input logic              rsp_trap,
  input logic [SYND_W-1:0] rsp_syndrome
);

  assert_level0_undef_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == PRIV_W'(0)) |=> (rsp_undef && !rsp_trap));

  assert_level1_trap_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == PRIV_W'(1) && trap_en) |=> (rsp_trap && rsp_syndrome == TRAP_SYND));

  assert_trap_undef_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(rsp_undef && rsp_trap));

  assert_level2_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == PRIV_W'(2) && !sre_l2) |=> rsp_undef);

  assert_unknown_view_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv >= PRIV_W'(2) && req_view > VIEW_W'(VIEW_EN)) |=> rsp_undef);

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_undef && !rsp_trap));

  assert_fault_zero_data_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_undef || rsp_trap) |-> (rsp_rdata == '0));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_view) == VIEW_W'(VIEW_PACKED)) |-> ((rsp_rdata & RSVD_MASK) == '0));

  assert_forced_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_undef && !rsp_trap &&
     $past(req_view == VIEW_W'(VIEW_PACKED) && !req_write && sre_fixed))
    |-> (rsp_rdata[POS_FIQ] && !rsp_rdata[POS_ACK]));

endmodule

bind vcpu_ifc_ctl vcpu_ifc_ctl_chk #(
  .PRIV_W(PRIV_W), .SYND_W(SYND_W), .TRAP_SYND(TRAP_SYND)
) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_view(req_view), .req_priv(req_priv), .trap_en(trap_en),
  .sre_l2(sre_l2), .sre_fixed(sre_fixed), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
  .rsp_syndrome(rsp_syndrome)
);

// File: tb/test_vcpu_ifc_ctl.sv
module test_vcpu_ifc_ctl;
  import vcpu_ifc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [2:0]  req_view;
  logic [1:0]  req_priv;
  logic [31:0] req_wdata;
  logic        trap_en, sre_l2, sre_l3, sre_fixed;
  logic        rsp_valid, rsp_undef, rsp_trap;
  logic [31:0] rsp_rdata;
  logic [5:0]  rsp_syndrome;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [31:0] last_rd;

  // behavioural model state
  int m_pm, m_b0, m_b1, m_eoi, m_cb, m_fiq, m_ack, m_e1, m_e0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcpu_ifc_ctl i_vcpu_ifc_ctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_priv(req_priv), .req_wdata(req_wdata),
    .trap_en(trap_en), .sre_l2(sre_l2), .sre_l3(sre_l3), .sre_fixed(sre_fixed),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef),
    .rsp_trap(rsp_trap), .rsp_syndrome(rsp_syndrome)
  );

  task automatic mdl_clear();
    m_pm = 0; m_b0 = 0; m_b1 = 0; m_eoi = 0; m_cb = 0;
    m_fiq = 0; m_ack = 0; m_e1 = 0; m_e0 = 0;
  endtask

  function automatic logic [31:0] mdl_read(int view, bit forced);
    int fiq = forced ? 1 : m_fiq;
    int ack = forced ? 0 : m_ack;
    int v = 0;
    case (view)
      0: v = (m_pm << 24) | (m_b0 << 21) | (m_b1 << 18) | (m_eoi << 9) |
             (m_cb << 4) | (fiq << 3) | (ack << 2) | (m_e1 << 1) | m_e0;
      1: v = m_pm;
      2: v = m_b0;
      3: v = (m_cb != 0) ? ((m_b0 == 7) ? 7 : m_b0 + 1) : m_b1;
      4: v = (ack << 3) | (fiq << 2) | (m_cb << 1) | m_eoi;
      5: v = (m_e1 << 1) | m_e0;
      default: v = 0;
    endcase
    return 32'(v);
  endfunction

  task automatic mdl_write(int view, logic [31:0] d);
    case (view)
      0: begin
        m_pm = int'(d[31:24]); m_b0 = int'(d[23:21]); m_b1 = int'(d[20:18]);
        m_eoi = int'(d[9]); m_cb = int'(d[4]); m_fiq = int'(d[3]);
        m_ack = int'(d[2]); m_e1 = int'(d[1]); m_e0 = int'(d[0]);
      end
      1: m_pm = int'(d[7:0]);
      2: m_b0 = int'(d[2:0]);
      3: if (m_cb == 0) m_b1 = int'(d[2:0]);
      4: begin m_eoi = int'(d[0]); m_cb = int'(d[1]); m_fiq = int'(d[2]); m_ack = int'(d[3]); end
      5: begin m_e0 = int'(d[0]); m_e1 = int'(d[1]); end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // drive at a falling edge, compare on the next falling edge
  task automatic access(int priv, bit wr, int view, logic [31:0] wd,
                        bit te, bit s2, bit s3, string tag);
    bit pass, trap, undef;
    logic [31:0] exp_d;
    pass = 0; trap = 0;
    if (priv == 1) trap = te;
    else if (priv == 2) pass = s2 && view <= 5;
    else if (priv == 3) pass = s3 && view <= 5;
    undef = !pass && !trap;
    exp_d = (pass && !wr) ? mdl_read(view, sre_fixed) : 32'h0;
    req_valid = 1'b1; req_write = wr; req_view = 3'(view); req_priv = 2'(priv);
    req_wdata = wd; trap_en = te; sre_l2 = s2; sre_l3 = s3;
    if (pass && wr) mdl_write(view, wd);
    @(negedge clk);
    req_valid = 1'b0;
    last_rd = rsp_rdata;
    chk(tag, "rsp_valid", 32'(rsp_valid), 32'h1);
    chk(tag, "rsp_undef", 32'(rsp_undef), 32'(undef));
    chk(tag, "rsp_trap", 32'(rsp_trap), 32'(trap));
    chk(tag, "rsp_syndrome", 32'(rsp_syndrome), trap ? 32'h3 : 32'h0);
    chk(tag, "rsp_rdata", rsp_rdata, exp_d);
  endtask

  task automatic rd(int view, string tag);
    access(2, 1'b0, view, 32'h0, 1'b0, 1'b1, 1'b1, tag);
  endtask

  task automatic wr(int view, logic [31:0] d, string tag);
    access(2, 1'b1, view, d, 1'b0, 1'b1, 1'b1, tag);
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    chk(tag, "idle rsp_valid", 32'(rsp_valid), 32'h0);
    chk(tag, "idle strobes", 32'({rsp_undef, rsp_trap}), 32'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mdl_clear();
    chk("R10", "reset rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R10", "reset rsp_rdata", rsp_rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_view = '0; req_priv = '0;
    req_wdata = '0; trap_en = 1'b0; sre_l2 = 1'b0; sre_l3 = 1'b0; sre_fixed = 1'b0;
    mdl_clear();
    @(negedge clk);
    do_reset();

    // R10: all fields zero after reset
    rd(0, "R10");
    chk("R10", "packed after reset", last_rd, 32'h0);
    idle_check("R11");

    // R1 R2: packed all-ones write, reserved bits stay zero
    wr(0, 32'hFFFF_FFFF, "R2");
    rd(0, "R1");
    chk("R1", "packed all ones", last_rd, 32'hFFFC_021F);
    chk("R11", "write response data", 32'h0, 32'h0);

    // R3 R4: narrow views of the same storage
    for (int v = 1; v <= 5; v++) rd(v, "R3");
    rd(3, "R4");
    chk("R4", "bp1 saturated", last_rd, 32'h7);

    // R1: distinct packed pattern
    wr(0, 32'h5A94_0215, "R1");
    rd(0, "R1");
    chk("R1", "packed pattern", last_rd, 32'h5A94_0215);

    // R3: narrow writes seen in packed view
    wr(1, 32'hFFFF_FF3C, "R3");
    wr(4, 32'h0000_0000, "R3");
    wr(5, 32'h0000_0002, "R3");
    rd(0, "R3");
    for (int v = 1; v <= 5; v++) rd(v, "R3");

    // R4 R5: derived group-1 binary point
    wr(3, 32'h5, "R5");
    wr(2, 32'h2, "R3");
    wr(4, 32'h2, "R4");
    rd(3, "R4");
    chk("R4", "bp1 = bp0+1", last_rd, 32'h3);
    wr(3, 32'h1, "R5");
    rd(0, "R5");
    chk("R5", "stored bp1 kept", 32'(last_rd[20:18]), 32'h5);
    wr(2, 32'h7, "R4");
    rd(3, "R4");
    wr(4, 32'h0, "R5");
    rd(3, "R5");
    chk("R5", "bp1 own value", last_rd, 32'h5);

    // R6: level 0 undefined, write has no effect
    access(0, 1'b0, 0, 32'h0, 1'b1, 1'b1, 1'b1, "R6");
    access(0, 1'b1, 0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, "R6");
    rd(0, "R11");

    // R7: level 1 trap or undefined
    access(1, 1'b0, 0, 32'h0, 1'b1, 1'b1, 1'b1, "R7");
    access(1, 1'b1, 1, 32'h0, 1'b1, 1'b1, 1'b1, "R7");
    access(1, 1'b1, 1, 32'h0, 1'b0, 1'b1, 1'b1, "R7");
    rd(1, "R11");

    // R8: per-level system-register enables
    access(2, 1'b1, 1, 32'h11, 1'b0, 1'b0, 1'b1, "R8");
    access(3, 1'b1, 1, 32'h22, 1'b0, 1'b1, 1'b0, "R8");
    access(3, 1'b1, 1, 32'h33, 1'b0, 1'b0, 1'b1, "R8");
    access(2, 1'b0, 1, 32'h0, 1'b0, 1'b1, 1'b0, "R8");
    chk("R8", "level3 write landed", last_rd, 32'h33);

    // R12: unknown views
    access(2, 1'b0, 6, 32'h0, 1'b0, 1'b1, 1'b1, "R12");
    access(3, 1'b1, 7, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, "R12");
    rd(0, "R12");

    // R9: forced bits under always-on configuration
    wr(4, 32'h8, "R9");
    sre_fixed = 1'b1;
    rd(0, "R9");
    chk("R9", "fiq forced 1 ack forced 0", 32'(last_rd[3:2]), 32'h2);
    rd(4, "R9");
    chk("R9", "ctrl view forced", 32'(last_rd[3:2]), 32'h1);
    sre_fixed = 1'b0;
    rd(4, "R9");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int p, vw;
      bit w, te, s2, s3;
      p  = ($urandom_range(0, 9) < 7) ? int'($urandom_range(2, 3)) : int'($urandom_range(0, 1));
      vw = ($urandom_range(0, 9) < 9) ? int'($urandom_range(0, 5)) : int'($urandom_range(6, 7));
      w  = 1'($urandom_range(0, 1));
      te = 1'($urandom_range(0, 1));
      s2 = ($urandom_range(0, 7) != 0);
      s3 = ($urandom_range(0, 7) != 0);
      sre_fixed = ($urandom_range(0, 5) == 0);
      access(p, w, vw, $urandom(), te, s2, s3, "R3");
      if ($urandom_range(0, 7) == 0) idle_check("R11");
    end
    sre_fixed = 1'b0;

    // R10: reset in the middle of a run
    wr(0, 32'hA5A5_A5A5, "R10");
    do_reset();
    rd(0, "R10");
    chk("R10", "packed after mid-run reset", last_rd, 32'h0);
    idle_check("R11");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule